// File: doc/BRIEF.md
# Two-Level Acquisition Timing Generator

This block produces the start pulses for an analog-input scan at two nested levels. A sample-level divider runs on a sample timebase and emits one sample-start pulse each time its period expires. Each sample start is carried into a separate convert timebase domain, which may be asynchronous to the sample domain. There it opens a burst of a fixed number of conversion-start pulses.

In divided mode, a second programmable divider on the convert timebase spaces the conversion pulses. In external mode, that divider is bypassed and each rising edge of an external convert input becomes a conversion start while a burst is open. Control inputs are captured on the falling edge of the timebase they belong to, so they are settled before the next rising edge acts on them. A per-domain parameter can invert either timebase before the active edge is chosen.

Arming starts the sample divider. Disarming stops new sample starts and closes any open burst at its next conversion. A sample start that arrives while a burst is still open raises a sticky overrun flag and is discarded.

Top module: `acq_timing_gen`

## Requirements
- R1: While and right after reset, `smp_start`, `armed`, `cnv_start`, `conv_busy` and `overrun` are all 0.
- R2: A one-cycle pulse on `arm_sw` or on `trig_in` is captured on a falling sample-timebase edge. `armed` rises at the next rising edge. With reload D, the first `smp_start` follows D+1 further rising edges.
- R3: While armed, `smp_start` is a one-cycle pulse repeating every `smp_reload`+1 sample-timebase cycles. The reload is 16 bits wide.
- R4: Each accepted sample start produces exactly N conversion pulses, where N = `cnv_count`+1. `cnv_count` is 4 bits wide, so N ranges from 1 to 16.
- R5: With `ext_mode`=0, the first conversion comes `cnv_reload`+1 convert-timebase cycles after the burst opens. Consecutive conversions in a burst are the same number of cycles apart.
- R6: With `ext_mode`=1, each rising edge of `ext_cnv` during an open burst gives one `cnv_start`, and `cnv_reload` has no effect on the spacing. Conversions are therefore spaced exactly as the `ext_cnv` edges are.
- R7: With `ext_mode`=1 and no burst open, edges on `ext_cnv` produce no `cnv_start`.
- R8: A sample start that arrives while `conv_busy` is high sets `overrun`, which stays set until the convert-domain reset. That sample start is dropped, so burst lengths remain N.
- R9: A pulse on `disarm_sw` clears `armed` at the next rising edge, and no further `smp_start` follows. An open burst ends with its next conversion, which is the last one.
- R10: `conv_busy` is high from an accepted sample start until the edge that issues the burst's last conversion. `cnv_start` only pulses when `conv_busy` was high on the previous convert-timebase cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Sample timebase |
| rst_smp | input | 1 | Synchronous active-high reset, sample domain |
| smp_reload | input | 16 | Sample divider reload value D (period D+1) |
| arm_sw | input | 1 | Software arm request |
| trig_in | input | 1 | Start-trigger arm request |
| disarm_sw | input | 1 | Disarm request |
| clk_cnv | input | 1 | Convert timebase |
| rst_cnv | input | 1 | Synchronous active-high reset, convert domain |
| cnv_reload | input | 16 | Convert divider reload value (period reload+1) |
| cnv_count | input | 4 | Conversions per sample minus one |
| ext_mode | input | 1 | 1: external convert input paces conversions |
| ext_cnv | input | 1 | External convert input |
| armed | output | 1 | Sample level running (sample domain) |
| smp_start | output | 1 | Sample-start pulse (sample domain) |
| cnv_start | output | 1 | Conversion-start pulse (convert domain) |
| conv_busy | output | 1 | Burst of conversions open (convert domain) |
| overrun | output | 1 | Sticky: a sample start was dropped |

## Verification
The hardest state to reach is a sample start landing on a burst that is still open, because it needs the two asynchronous timebases set against each other. The bench gets there with a short sample period, the longest burst and a slow convert divider. It then checks that overrun is set and that every recorded burst still has full length. A disarm that lands in the middle of a burst is also hard to reach. The bench waits on the count of observed conversions before it sends the disarm, and then expects exactly one more conversion.

// File: rtl/acq_timing_pkg.sv
package acq_timing_pkg;

    localparam int DIV_W = 16;
    localparam int CNT_W = 4;

    typedef logic [DIV_W-1:0] reload_t;
    typedef logic [CNT_W-1:0] burst_t;

    typedef enum logic {
        CNV_DIVIDED  = 1'b0,
        CNV_EXTERNAL = 1'b1
    } cnv_src_e;

    typedef struct packed {
        reload_t cnt;
        logic    tick;
    } div_st_t;

    // One timebase edge of a down-counting divider: period = reload + 1.
    function automatic div_st_t div_step(div_st_t s, reload_t rl, logic load, logic run);
        div_st_t n;
        n.tick = 1'b0;
        n.cnt  = s.cnt;
        if (load) begin
            n.cnt = rl;
        end else if (run) begin
            if (s.cnt == '0) begin
                n.tick = 1'b1;
                n.cnt  = rl;
            end else begin
                n.cnt = s.cnt - 1'b1;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/atg_fall_cap.sv
module atg_fall_cap #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture on the inactive edge so the value is settled for the next active edge.
    always_ff @(negedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/atg_divider.sv
module atg_divider
    import acq_timing_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  logic    run,
    input  reload_t reload,
    output logic    tick
);
    div_st_t st;

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= div_step(st, reload, load, run);
    end

    assign tick = st.tick;

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick && reload != '0) |=> !tick); // R3
endmodule

// File: rtl/atg_smp_level.sv
module atg_smp_level
    import acq_timing_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  reload_t reload,
    input  logic    arm_sw,
    input  logic    trig_in,
    input  logic    disarm_sw,
    output logic    armed,
    output logic    smp_start,
    output logic    smp_tog
);
    logic [2:0] req_c;
    logic       arm_req, stop_req, div_tick;

    atg_fall_cap #(.W(3)) u_cap (
        .clk (clk),
        .rst (rst),
        .d   ({disarm_sw, trig_in, arm_sw}),
        .q   (req_c)
    );

    assign arm_req  = req_c[0] | req_c[1];
    assign stop_req = req_c[2];

    atg_divider u_div (
        .clk    (clk),
        .rst    (rst),
        .load   (arm_req & ~armed & ~stop_req),
        .run    (armed & ~stop_req),
        .reload (reload),
        .tick   (div_tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            smp_tog <= 1'b0;
        end else begin
            if (stop_req)     armed <= 1'b0;
            else if (arm_req) armed <= 1'b1;
            if (div_tick)     smp_tog <= ~smp_tog;
        end
    end

    assign smp_start = div_tick;

    AST_IDLE_WHEN_DISARMED: assert property (@(posedge clk) disable iff (rst)
        !armed |=> !smp_start); // R9
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> !armed); // R9
endmodule

// File: rtl/atg_cnv_level.sv
module atg_cnv_level
    import acq_timing_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  reload_t reload,
    input  burst_t  count,
    input  logic    ext_mode,
    input  logic    ext_cnv,
    input  logic    smp_tog,
    input  logic    armed_in,
    output logic    cnv_start,
    output logic    busy,
    output logic    overrun
);
    logic [2:0] tog_s;
    logic [1:0] arm_s;
    logic       ext_c, ext_q;
    logic       start_evt, div_tick, conv;
    burst_t     remain;
    cnv_src_e   src;

    assign src = cnv_src_e'(ext_mode);

    atg_fall_cap #(.W(1)) u_ext_cap (
        .clk (clk),
        .rst (rst),
        .d   (ext_cnv),
        .q   (ext_c)
    );

    // Toggle handoff of each sample start from the sample domain.
    always_ff @(posedge clk) begin
        if (rst) begin
            tog_s <= '0;
            arm_s <= '0;
            ext_q <= 1'b0;
        end else begin
            tog_s <= {tog_s[1:0], smp_tog};
            arm_s <= {arm_s[0], armed_in};
            ext_q <= ext_c;
        end
    end

    assign start_evt = tog_s[2] ^ tog_s[1];

    atg_divider u_div (
        .clk    (clk),
        .rst    (rst),
        .load   (start_evt & ~busy),
        .run    (busy & (src == CNV_DIVIDED)),
        .reload (reload),
        .tick   (div_tick)
    );

    assign conv = busy & ((src == CNV_EXTERNAL) ? (ext_c & ~ext_q) : div_tick);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            remain    <= '0;
            cnv_start <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            cnv_start <= conv;
            if (start_evt && busy) overrun <= 1'b1;
            if (conv) begin
                if (remain == '0 || !arm_s[1]) busy <= 1'b0;
                else                            remain <= remain - 1'b1;
            end else if (start_evt && !busy) begin
                busy   <= 1'b1;
                remain <= count;
            end
        end
    end

    AST_CONV_IN_BURST: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !cnv_start); // R10
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R8
    AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        (start_evt && busy) |=> overrun); // R8
    AST_DROP_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (start_evt && busy && !conv) |=> busy); // R8
endmodule

// File: rtl/acq_timing_gen.sv
module acq_timing_gen
    import acq_timing_pkg::*;
#(
    parameter bit SMP_TB_INV = 1'b0,
    parameter bit CNV_TB_INV = 1'b0
) (
    input  logic        clk_smp,
    input  logic        rst_smp,
    input  logic [15:0] smp_reload,
    input  logic        arm_sw,
    input  logic        trig_in,
    input  logic        disarm_sw,
    input  logic        clk_cnv,
    input  logic        rst_cnv,
    input  logic [15:0] cnv_reload,
    input  logic [3:0]  cnv_count,
    input  logic        ext_mode,
    input  logic        ext_cnv,
    output logic        armed,
    output logic        smp_start,
    output logic        cnv_start,
    output logic        conv_busy,
    output logic        overrun
);
    logic smp_act, cnv_act, smp_tog;

    // Polarity select ahead of active-edge choice, one per timebase.
    assign smp_act = clk_smp ^ SMP_TB_INV;
    assign cnv_act = clk_cnv ^ CNV_TB_INV;

    atg_smp_level u_smp (
        .clk       (smp_act),
        .rst       (rst_smp),
        .reload    (smp_reload),
        .arm_sw    (arm_sw),
        .trig_in   (trig_in),
        .disarm_sw (disarm_sw),
        .armed     (armed),
        .smp_start (smp_start),
        .smp_tog   (smp_tog)
    );

    atg_cnv_level u_cnv (
        .clk       (cnv_act),
        .rst       (rst_cnv),
        .reload    (cnv_reload),
        .count     (cnv_count),
        .ext_mode  (ext_mode),
        .ext_cnv   (ext_cnv),
        .smp_tog   (smp_tog),
        .armed_in  (armed),
        .cnv_start (cnv_start),
        .busy      (conv_busy),
        .overrun   (overrun)
    );
endmodule

// File: tb/acq_timing_gen_bench.sv
`timescale 1ns/100ps
module acq_timing_gen_bench;

    logic        clk_smp = 1'b0, clk_cnv = 1'b0;
    logic        rst_smp = 1'b1, rst_cnv = 1'b1;
    logic [15:0] smp_reload = '0, cnv_reload = '0;
    logic [3:0]  cnv_count = '0;
    logic        arm_sw = 1'b0, trig_in = 1'b0, disarm_sw = 1'b0;
    logic        ext_mode = 1'b0, ext_cnv = 1'b0;
    logic        armed, smp_start, cnv_start, conv_busy, overrun;

    int n_tests = 0, n_fail = 0;

    always #2.0 clk_smp = ~clk_smp;
    always #3.1 clk_cnv = ~clk_cnv;

    acq_timing_gen u_acq_timing_gen (
        .clk_smp(clk_smp), .rst_smp(rst_smp), .smp_reload(smp_reload),
        .arm_sw(arm_sw), .trig_in(trig_in), .disarm_sw(disarm_sw),
        .clk_cnv(clk_cnv), .rst_cnv(rst_cnv), .cnv_reload(cnv_reload),
        .cnv_count(cnv_count), .ext_mode(ext_mode), .ext_cnv(ext_cnv),
        .armed(armed), .smp_start(smp_start), .cnv_start(cnv_start),
        .conv_busy(conv_busy), .overrun(overrun)
    );

    // ---------------- monitors ----------------
    int cyc_s = 0, smp_n = 0, last_s = -1, sgap_min = 1 << 30, sgap_max = 0;
    always @(negedge clk_smp) begin
        if (smp_start) begin
            smp_n++;
            if (last_s >= 0) begin
                if (cyc_s - last_s < sgap_min) sgap_min = cyc_s - last_s;
                if (cyc_s - last_s > sgap_max) sgap_max = cyc_s - last_s;
            end
            last_s = cyc_s;
        end
        cyc_s++;
    end

    int cyc_c = 0, cnv_n = 0, last_c = -1, cgap_min = 1 << 30;
    int cur_b = 0, bursts = 0, bmin = 1 << 30, bmax = 0, nobusy = 0;
    bit busy_prev = 1'b0, b_valid = 1'b0;
    always @(negedge clk_cnv) begin
        if (!busy_prev && conv_busy) begin cur_b = 0; b_valid = 1'b1; end
        if (cnv_start) begin
            cnv_n++;
            cur_b++;
            if (!busy_prev) nobusy++;
            if (last_c >= 0 && cyc_c - last_c < cgap_min) cgap_min = cyc_c - last_c;
            last_c = cyc_c;
        end
        if (busy_prev && !conv_busy && b_valid) begin
            bursts++;
            if (cur_b < bmin) bmin = cur_b;
            if (cur_b > bmax) bmax = cur_b;
        end
        busy_prev = conv_busy;
        cyc_c++;
    end

    bit ext_run = 1'b0;
    always begin
        if (ext_run) begin
            @(posedge clk_cnv); #1 ext_cnv = 1'b1;
            @(posedge clk_cnv); #1 ext_cnv = 1'b0;
            @(posedge clk_cnv); @(posedge clk_cnv);
        end else begin
            @(posedge clk_cnv);
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        smp_n = 0; last_s = -1; sgap_min = 1 << 30; sgap_max = 0;
        cnv_n = 0; last_c = -1; cgap_min = 1 << 30;
        bursts = 0; bmin = 1 << 30; bmax = 0; nobusy = 0; b_valid = 1'b0;
    endtask

    task automatic do_reset();
        arm_sw = 0; trig_in = 0; disarm_sw = 0; ext_cnv = 0;
        rst_smp = 1; rst_cnv = 1;
        repeat (10) @(posedge clk_cnv);
        #1 rst_smp = 0; rst_cnv = 0;
        repeat (2) @(posedge clk_cnv);
        #1 clr_mon();
    endtask

    task automatic arm_timed(input bit via_trig, output int k);
        @(posedge clk_smp); #1;
        if (via_trig) trig_in = 1; else arm_sw = 1;
        @(posedge clk_smp); #1;
        arm_sw = 0; trig_in = 0;
        k = 1;
        while (k < 100000) begin
            @(negedge clk_smp);
            if (smp_start) break;
            @(posedge clk_smp);
            k++;
        end
    endtask

    task automatic wait_bursts(input int n);
        for (int i = 0; i < 20000 && bursts < n; i++) @(posedge clk_smp);
        #1;
    endtask

    initial begin
        int k;
        do_reset();
        // R1 reset state
        check(smp_start == 0 && armed == 0, "R1 sample outputs", {armed, smp_start}, 0);
        check(cnv_start == 0 && conv_busy == 0 && overrun == 0, "R1 convert outputs",
              {cnv_start, conv_busy, overrun}, 0);

        // R2/R3 sweep of sample reload
        for (int d = 0; d < 8; d++) begin
            do_reset();
            smp_reload = 16'(d); cnv_count = 0; cnv_reload = 0; ext_mode = 0;
            arm_timed(d[0], k);
            check(k == d + 2, "R2 first sample latency", k, d + 2);
            check(armed == 1, "R2 armed", armed, 1);
            clr_mon();
            for (int i = 0; i < 200 && smp_n < 6; i++) @(posedge clk_smp);
            #1;
            check(sgap_min == d + 1 && sgap_max == d + 1, "R3 sample period", sgap_max, d + 1);
        end

        // R4/R5/R10 sweep of convert reload and burst length
        for (int dc = 0; dc < 4; dc++) begin
            for (int j = 0; j < 5; j++) begin
                int n;
                n = (j == 0) ? 1 : (j == 1) ? 2 : (j == 2) ? 3 : (j == 3) ? 8 : 16;
                do_reset();
                smp_reload = 16'd299; cnv_reload = 16'(dc); cnv_count = 4'(n - 1); ext_mode = 0;
                arm_timed(1'b0, k);
                clr_mon();
                wait_bursts(3);
                check(bmin == n && bmax == n, "R4 conversions per sample", bmax, n);
                if (n > 1) check(cgap_min == dc + 1, "R5 convert spacing", cgap_min, dc + 1);
                check(nobusy == 0, "R10 conversion outside burst", nobusy, 0);
                check(overrun == 0, "R8 no overrun when slow", overrun, 0);
            end
        end

        // R8 overrun: fast samples, long bursts
        do_reset();
        smp_reload = 16'd3; cnv_reload = 16'd5; cnv_count = 4'd15; ext_mode = 0;
        arm_timed(1'b0, k);
        clr_mon();
        wait_bursts(2);
        check(overrun == 1, "R8 overrun set", overrun, 1);
        check(bmin == 16 && bmax == 16, "R8 dropped starts keep length", bmax, 16);

        // R6 external mode, convert reload ignored
        do_reset();
        smp_reload = 16'd299; cnv_reload = 16'd9; cnv_count = 4'd3; ext_mode = 1;
        ext_run = 1;
        arm_timed(1'b0, k);
        clr_mon();
        wait_bursts(3);
        ext_run = 0;
        check(bmin == 4 && bmax == 4, "R6 external burst length", bmax, 4);
        check(cgap_min == 4, "R6 spacing follows ext edges", cgap_min, 4);
        check(nobusy == 0, "R10 ext conversion outside burst", nobusy, 0);

        // R9 disarm mid-burst
        do_reset();
        smp_reload = 16'd999; cnv_reload = 16'd20; cnv_count = 4'd15; ext_mode = 0;
        arm_timed(1'b0, k);
        for (int i = 0; i < 20000 && cnv_n < 3; i++) @(negedge clk_cnv);
        @(posedge clk_smp); #1 disarm_sw = 1;
        @(posedge clk_smp); #1 disarm_sw = 0;
        @(posedge clk_smp); #1;
        check(armed == 0, "R9 armed cleared", armed, 0);
        clr_mon();
        repeat (1200) @(posedge clk_smp);
        #1;
        check(smp_n == 0, "R9 no sample after disarm", smp_n, 0);
        check(cnv_n == 1, "R9 one closing conversion", cnv_n, 1);
        check(conv_busy == 0, "R9 burst closed", conv_busy, 0);

        // R7 external edges with no burst open
        ext_mode = 1;
        clr_mon();
        ext_run = 1;
        repeat (100) @(posedge clk_cnv);
        ext_run = 0;
        repeat (5) @(posedge clk_cnv);
        #1;
        check(cnv_n == 0, "R7 idle ext edges ignored", cnv_n, 0);
        check(conv_busy == 0, "R7 stays idle", conv_busy, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #700us;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule